// File: doc/BRIEF.md
# Integer Compare Flag Generator

This block compares two signed integers held in a bank of 64-bit registers and reports the outcome as four condition flags packed into the top of a 32-bit transfer word. A compare request gives two register indices and a width select. In narrow mode only the low 32 bits of each register take part. In wide mode all 64 bits take part. The flags describe the difference A minus B. N is the sign of the difference and Z marks a zero difference. C is a no-borrow indication built from the sign bits. V marks signed overflow of the subtraction.

The register bank sits inside the block and has one write port and two combinational read ports. A compare reads both operands in the cycle of its request. The flag word and a done strobe are registered and appear one clock after the request. A host can therefore issue a compare on every cycle. The word keeps its last value in cycles with no request.

Top module: `cmp_flag_unit`

## Requirements
- R1: While `rst` is high, the next clock edge drives `flag_done` to 0 and `flag_word` to 0.
- R2: `flag_done` is 1 in exactly the cycle after a cycle with `cmp_valid` high. After a cycle without a request, `flag_word` keeps its previous value.
- R3: With `cmp_wide`=0 the operands are bits 31:0 of the two registers, and bits 63:32 have no effect on any flag.
- R4: With `cmp_wide`=1 the operands are the full 64-bit register values.
- R5: Z, at bit 30, is 1 exactly when A minus B is zero at the selected width.
- R6: N, at bit 31, is the most significant bit of A minus B at the selected width.
- R7: C, at bit 29, is 1 exactly when A is greater than or equal to B read as unsigned numbers, meaning the subtraction needs no borrow.
- R8: V, at bit 28, is 1 exactly when the signed subtraction overflows, so that N differs from the true signed result of A less than B.
- R9: Bits 27:0 of `flag_word` are always 0.
- R10: A write to the bank takes effect at the clock edge. A compare in the same cycle as a write to one of its operand registers uses the contents from before that write.
- R11: Operand A comes from register `idx_a` and operand B from register `idx_b`. When both indices are equal, the flag nibble is 4'b0110 (Z and C set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the register bank |
| wr_idx | input | 4 | Register written when `wr_en` is high |
| wr_data | input | 64 | Value to write |
| cmp_valid | input | 1 | Compare request strobe |
| idx_a | input | 4 | Register index of operand A (minuend) |
| idx_b | input | 4 | Register index of operand B (subtrahend) |
| cmp_wide | input | 1 | 0 compares the low 32 bits, 1 compares all 64 bits |
| flag_word | output | 32 | {N, Z, C, V, 28 zero bits}, registered |
| flag_done | output | 1 | High for one cycle when `flag_word` carries a new result |

## Verification
The bench loads registers with the signed extremes of both widths: most-negative and most-positive values, -1, zero, and values whose low half is an extreme while the high half holds unrelated bits. It then compares every pair in both modes. A design that took the flags from the 64-bit lane in narrow mode would report wrong N and C wherever the upper halves differ. A design that used the wrong sign bit for overflow would miss V at the most-negative/positive boundary. A carry that meant "borrow" instead of "no borrow" would invert C on every unequal pair. Random traffic mixes in idle cycles and writes to registers that are being compared in the same cycle. These catch a word that drifts while idle, and a bank that forwards the new write data into a compare issued in the same cycle.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  typedef enum logic {
    CMPF_NARROW = 1'b0,
    CMPF_WIDE   = 1'b1
  } cmpf_width_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cmpf_flags_t;

  localparam int CMPF_FLAG_BITS = $bits(cmpf_flags_t);

  function automatic logic [31:0] cmpf_pack32(cmpf_flags_t f);
    return {f, {(32 - CMPF_FLAG_BITS){1'b0}}};
  endfunction

endpackage

// File: rtl/cmpf_regbank.sv
module cmpf_regbank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);

  // Distributed-RAM style: one synchronous write, combinational reads.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];

endmodule

// File: rtl/cmpf_flag_calc.sv
module cmpf_flag_calc
  import cmpf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmpf_flags_t  flags_o
);

  logic [W-1:0] diff;
  logic a_neg, b_neg, r_neg;

  assign diff  = a_i - b_i;
  assign a_neg = a_i[W-1];
  assign b_neg = b_i[W-1];
  assign r_neg = diff[W-1];

  always_comb begin
    flags_o.n = r_neg;
    flags_o.z = ~|diff;
    // Overflow: operand signs differ and the result sign disagrees with A.
    flags_o.v = (a_neg & ~b_neg & ~r_neg) | (~a_neg & b_neg & r_neg);
    // No-borrow from the sign bits of A, B and the difference.
    flags_o.c = (a_neg & ~b_neg) | (a_neg & ~r_neg) | (~b_neg & ~r_neg);
  end

endmodule

// File: rtl/cmpf_out_reg.sv
module cmpf_out_reg
  import cmpf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              wide_i,
  input  cmpf_flags_t       narrow_flags_i,
  input  cmpf_flags_t       wide_flags_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);

  localparam int PAD_W = WORD_W - CMPF_FLAG_BITS;

  cmpf_flags_t sel_flags;

  always_comb begin
    if (cmpf_width_e'(wide_i) == CMPF_WIDE) sel_flags = wide_flags_i;
    else                                    sel_flags = narrow_flags_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        word_o <= {sel_flags, {PAD_W{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmpf_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int REG_W     = 64,
  parameter int NARROW_W  = 32,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int LANES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic              cmp_wide,
  output logic [WORD_W-1:0] flag_word,
  output logic              flag_done
);

  logic [REG_W-1:0] opa, opb;
  cmpf_flags_t      lane_flags [LANES];

  cmpf_regbank #(
    .DEPTH  (REG_COUNT),
    .DATA_W (REG_W)
  ) u_bank (
    .clk       (clk),
    .we_i      (wr_en),
    .waddr_i   (wr_idx),
    .wdata_i   (wr_data),
    .raddr_a_i (idx_a),
    .raddr_b_i (idx_b),
    .rdata_a_o (opa),
    .rdata_b_o (opb)
  );

  // Lane 0 evaluates the low half, lane 1 the full register.
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int LW = (gi == 0) ? NARROW_W : REG_W;
    cmpf_flag_calc #(.W(LW)) u_calc (
      .a_i     (opa[LW-1:0]),
      .b_i     (opb[LW-1:0]),
      .flags_o (lane_flags[gi])
    );
  end

  cmpf_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk            (clk),
    .rst            (rst),
    .valid_i        (cmp_valid),
    .wide_i         (cmp_wide),
    .narrow_flags_i (lane_flags[0]),
    .wide_flags_i   (lane_flags[1]),
    .word_o         (flag_word),
    .done_o         (flag_done)
  );

endmodule

// File: rtl/cmpf_checker.sv
module cmpf_checker #(
  parameter int IDX_W  = 4,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_valid,
  input logic [IDX_W-1:0]  idx_a,
  input logic [IDX_W-1:0]  idx_b,
  input logic [WORD_W-1:0] flag_word,
  input logic              flag_done
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!flag_done && flag_word == '0));

  assert_done_after_valid_R2: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> flag_done);

  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> !flag_done);

  assert_word_held_R2: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(flag_word));

  assert_zero_means_no_borrow_R7: assert property (@(posedge clk) disable iff (rst)
    flag_word[WORD_W-2] |-> flag_word[WORD_W-3]);

  assert_zero_excludes_n_v_R5: assert property (@(posedge clk) disable iff (rst)
    flag_word[WORD_W-2] |-> (!flag_word[WORD_W-1] && !flag_word[WORD_W-4]));

  assert_low_bits_clear_R9: assert property (@(posedge clk) disable iff (rst)
    flag_word[WORD_W-5:0] == '0);

  assert_same_index_R11: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && idx_a == idx_b) |=> (flag_word[WORD_W-1:WORD_W-4] == 4'b0110));

endmodule

bind cmp_flag_unit cmpf_checker #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_cmpf_checker (
  .clk       (clk),
  .rst       (rst),
  .cmp_valid (cmp_valid),
  .idx_a     (idx_a),
  .idx_b     (idx_b),
  .flag_word (flag_word),
  .flag_done (flag_done)
);

// File: tb/test_cmp_flag_unit.sv
`timescale 1ns/1ps
module test_cmp_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        cmp_valid = 1'b0;
  logic [3:0]  idx_a = '0;
  logic [3:0]  idx_b = '0;
  logic        cmp_wide = 1'b0;
  logic [31:0] flag_word;
  logic        flag_done;

  always #2.5 clk = ~clk;

  cmp_flag_unit i_cmp_flag_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cmp_valid(cmp_valid), .idx_a(idx_a), .idx_b(idx_b), .cmp_wide(cmp_wide),
    .flag_word(flag_word), .flag_done(flag_done)
  );

  logic [63:0] mdl [16];
  logic [31:0] exp_word;
  logic        exp_done;
  int checks = 0, errors = 0, cycles = 0;
  bit compare_on = 0;
  string phase = "reset";

  // Reference flags from unsigned/signed ordering, not from sign-bit terms.
  function automatic logic [31:0] ref_word(logic [63:0] ra, logic [63:0] rb, logic wide);
    logic n, z, c, v, lt;
    logic [63:0] d64;
    logic [31:0] d32;
    if (wide) begin
      d64 = ra - rb;
      n = d64[63]; z = (d64 == 64'd0); c = (ra >= rb);
      lt = ($signed(ra) < $signed(rb));
    end else begin
      d32 = ra[31:0] - rb[31:0];
      n = d32[31]; z = (d32 == 32'd0); c = (ra[31:0] >= rb[31:0]);
      lt = ($signed(ra[31:0]) < $signed(rb[31:0]));
    end
    v = (lt != n);
    return {n, z, c, v, 28'd0};
  endfunction

  function automatic logic [63:0] seed_val(int i);
    case (i)
      0:  return 64'h0000000000000000;
      1:  return 64'h0000000000000001;
      2:  return 64'hFFFFFFFFFFFFFFFF;
      3:  return 64'h000000007FFFFFFF;
      4:  return 64'hDEADBEEF80000000;
      5:  return 64'h7FFFFFFFFFFFFFFF;
      6:  return 64'h8000000000000000;
      7:  return 64'h1234567800000000;
      8:  return 64'hFFFFFFFF80000000;
      9:  return 64'h00000000FFFFFFFF;
      10: return 64'h8000000000000001;
      11: return 64'h7FFFFFFF7FFFFFFF;
      12: return 64'h0000000100000000;
      13: return 64'hFFFFFFFEFFFFFFFF;
      14: return 64'h0000000A0000000A;
      default: return 64'hA5A5A5A55A5A5A5A;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference model, updated on the same edge as the design.
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      exp_word <= '0;
      exp_done <= 1'b0;
    end else begin
      exp_done <= cmp_valid;
      if (cmp_valid) exp_word <= ref_word(mdl[idx_a], mdl[idx_b], cmp_wide);
    end
    if (wr_en) mdl[wr_idx] <= wr_data;
    if (cycles > 60000) begin
      errors++;
      $display("FAIL R2 watchdog: actual=%0d expected<=%0d cycles", cycles, 60000);
      summary();
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (compare_on) begin
      chk("R2 done",  flag_done,       exp_done);
      chk("R6 N",     flag_word[31],   exp_word[31]);
      chk("R5 Z",     flag_word[30],   exp_word[30]);
      chk("R7 C",     flag_word[29],   exp_word[29]);
      chk("R8 V",     flag_word[28],   exp_word[28]);
      chk("R9 low",   flag_word[27:0], 28'd0);
    end
  end

  task automatic idle();
    wr_en = 0; cmp_valid = 0;
    @(negedge clk);
  endtask

  task automatic wr(int i, logic [63:0] v);
    wr_en = 1; wr_idx = 4'(i); wr_data = v; cmp_valid = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cmp(int a, int b, logic w);
    cmp_valid = 1; idx_a = 4'(a); idx_b = 4'(b); cmp_wide = w;
    @(negedge clk);
    cmp_valid = 0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    phase = "R1 reset";
    chk("R1 done", flag_done, 1'b0);
    chk("R1 word", flag_word, 32'd0);
    rst = 0;
    compare_on = 1;
    phase = "load";
    for (int i = 0; i < 16; i++) wr(i, seed_val(i));
    idle();

    phase = "R8 directed";
    cmp(4, 1, 1'b0);
    chk("R3 R8 narrow min minus one", flag_word, 32'h30000000);
    cmp(4, 1, 1'b1);
    chk("R4 R6 wide negative", flag_word, 32'hA0000000);
    idle();
    chk("R2 hold", flag_word, 32'hA0000000);
    cmp(7, 0, 1'b0);
    chk("R3 R5 upper half ignored", flag_word, 32'h60000000);

    phase = "R3 narrow all pairs";
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) cmp(a, b, 1'b0);
    phase = "R4 wide all pairs";
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) cmp(a, b, 1'b1);
    phase = "R11 same index";
    for (int a = 0; a < 16; a++) begin
      cmp(a, a, a[0]);
      chk("R11 same index nibble", flag_word[31:28], 4'b0110);
    end

    phase = "R10 write collision";
    wr_en = 1; wr_idx = 4'd3; wr_data = 64'h8000000000000000;
    cmp_valid = 1; idx_a = 4'd3; idx_b = 4'd0; cmp_wide = 1'b1;
    @(negedge clk);
    wr_en = 0; cmp_valid = 0;
    chk("R10 old contents used", flag_word, 32'h20000000);
    cmp(3, 0, 1'b1);
    chk("R10 new contents visible", flag_word, 32'hA0000000);

    phase = "random traffic";
    for (int k = 0; k < 4000; k++) begin
      cmp_valid = ($urandom_range(0, 9) < 7);
      idx_a = 4'($urandom_range(0, 15));
      idx_b = 4'($urandom_range(0, 15));
      cmp_wide = 1'($urandom_range(0, 1));
      wr_en = ($urandom_range(0, 9) < 3);
      wr_idx = 4'($urandom_range(0, 15));
      wr_data = seed_val($urandom_range(0, 15)) ^ ({$urandom, $urandom} & {64{$urandom_range(0, 1) == 1}});
      @(negedge clk);
    end
    idle();
    idle();
    summary();
  end

endmodule